// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five hardware interrupt lines and picks the one to service next. A non-maskable emergency line always wins. Three restart lines, numbered 7.5, 6.5 and 5.5, follow it in priority. A general request line comes last. The 7.5 line is captured on a rising edge and held in a latch. The 6.5, 5.5 and general lines are level-sensitive. The emergency line must be high and must also have risen since it was last serviced.

Whenever a source is eligible, the block raises a pending flag and drives the 16-bit entry address of the winner. Each restart entry address is eight times its restart number: 0x0024 (4.5), 0x003C (7.5), 0x0034 (6.5) and 0x002C (5.5). The general line drives a parameter value, by default 0x0000, because the device supplies the real target.

The processor side controls the block with these inputs:
- Enable and disable pulses for a global interrupt-enable bit.
- A mask write.
- A service pulse that acknowledges the current winner.

A status word reports the masks, the enable bit and the raw pending state of the restart lines. When a general request is serviced, an active-low acknowledge strobe is driven for one cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When several sources are eligible together, the winner follows the fixed order, highest first: emergency, 7.5, 6.5, 5.5, general. The winner's entry address is driven on `vec_o`: 0x0024, 0x003C, 0x0034, 0x002C, or GEN_VEC for the general line.
- R2: The emergency line pends even when the enable bit is clear and all three masks are set.
- R3: The emergency line is eligible only while `trap_i` is high and a rising edge has been seen since its last service. Held high after service, it stays idle. After a low-then-high transition, it pends again, visible one clock after the rise.
- R4: A rising edge on `r75_i` sets a latch, visible one clock later, that outlives the input pulse. Acknowledging the 7.5 source clears the latch, and an input held high afterwards does not set it again.
- R5: A mask write with `ctl_data_i[4]` = 1 clears the 7.5 latch. If a new rising edge arrives in the same cycle, the latch stays set.
- R6: The 6.5 and 5.5 lines pend only while their inputs are high, with no latching.
- R7: A mask write applies `ctl_data_i[2:0]` as masks {7.5, 6.5, 5.5} only when `ctl_data_i[3]` = 1. Otherwise the masks are unchanged. A masked source never wins. After reset all three masks are 1.
- R8: The enable bit is 0 after reset. `ie_set_i` sets it. `ie_clr_i` clears it and takes precedence over a simultaneous set. An accepted service pulse clears it and takes precedence over a simultaneous set. While the bit is 0, only the emergency line can pend.
- R9: Servicing a general-line winner drives `inta_no` low for exactly the one cycle after the service pulse. Servicing any other source leaves `inta_no` high.
- R10: `status_o` holds the masks in bits 2:0, the enable bit in bit 3, and the raw pending state of {7.5 latch, 6.5 input, 5.5 input} in bits 6:4. Bit 7 reads 0.
- R11: A service pulse while nothing is pending changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable emergency request |
| r75_i | input | 1 | Restart 7.5 request, rising-edge latched |
| r65_i | input | 1 | Restart 6.5 request, level |
| r55_i | input | 1 | Restart 5.5 request, level |
| gen_i | input | 1 | General request, level, lowest priority |
| ie_set_i | input | 1 | Pulse that sets the enable bit |
| ie_clr_i | input | 1 | Pulse that clears the enable bit |
| mask_wr_i | input | 1 | Mask-write strobe |
| ctl_data_i | input | 8 | Mask-write data: masks 2:0, apply 3, clear 7.5 latch 4 |
| ack_i | input | 1 | Service pulse for the current winner |
| irq_pend_o | output | 1 | An eligible source exists |
| vec_o | output | VEC_W (16) | Entry address of the winner |
| inta_no | output | 1 | Active-low acknowledge for the general line |
| status_o | output | 8 | Masks, enable bit and pending bits |

## Verification
Two pairs of functions can land in the same clock.

The first pair is a service pulse and an enable pulse. The bench raises both on one edge while a 5.5 request is pending. The enable bit must read 0 afterwards.

The second pair is a latch-clearing mask write and a new 7.5 rising edge. The bench drives both together and expects bit 6 of the status word to remain 1. A second write, with the input held high, must then clear it.

The priority order is checked by serving every source in turn from a single cycle in which all five are asserted.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   localparam int NUM_SRC      = 5;
   localparam int CTL_W        = 8;
   localparam int MASK_W       = 3;
   localparam int MW_SET_BIT   = 3;
   localparam int MW_CLR75_BIT = 4;
   localparam int ST_IE_BIT    = 3;
   localparam int ST_PEND_LSB  = 4;
   localparam int VEC_UNIT     = 4;   // bytes per half restart step

   // source index equals priority rank, 0 highest
   typedef enum logic [2:0] {
      SRC_TRAP = 3'd0,
      SRC_R75  = 3'd1,
      SRC_R65  = 3'd2,
      SRC_R55  = 3'd3,
      SRC_GEN  = 3'd4,
      SRC_NONE = 3'd7
   } src_e;

   // entry address = restart number * 8 = half steps * 4
   function automatic logic [15:0] src_vector(input int idx, input logic [15:0] gen_vec);
      case (idx)
         0:       return 16'(9  * VEC_UNIT);
         1:       return 16'(15 * VEC_UNIT);
         2:       return 16'(13 * VEC_UNIT);
         3:       return 16'(11 * VEC_UNIT);
         default: return gen_vec;
      endcase
   endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic clr_i,
   output logic rise_o,
   output logic flag_o
);

   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     flag_o <= 1'b0;
            else if (rise_o) flag_o <= 1'b1;
            else if (clr_i)  flag_o <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     flag_o <= 1'b0;
            else if (clr_i)  flag_o <= 1'b0;
            else if (rise_o) flag_o <= 1'b1;
         end
      end
   endgenerate

   p_rise_captured_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_o && (SET_WINS || !clr_i)) |=> flag_o);

   p_flag_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
   import prio_irq_pkg::*;
#(
   parameter int M_W = MASK_W,
   parameter int D_W = CTL_W
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           en_i,
   input  logic           dis_i,
   input  logic           ack_i,
   input  logic           mw_i,
   input  logic [D_W-1:0] mw_data_i,
   output logic           ie_o,
   output logic [M_W-1:0] mask_o
);

   if (MW_SET_BIT < M_W || MW_SET_BIT >= D_W) begin : g_bad_layout
      $error("irq_ctrl_regs: apply bit overlaps masks or exceeds data width");
   end

   logic apply_w;
   assign apply_w = mw_i & mw_data_i[MW_SET_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            ie_o <= 1'b0;
      else if (ack_i | dis_i) ie_o <= 1'b0;
      else if (en_i)          ie_o <= 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mask_o <= '1;
      else if (apply_w) mask_o <= mw_data_i[M_W-1:0];
   end

   p_ack_clears_ie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i |=> !ie_o);

   p_mask_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mw_i && mw_data_i[MW_SET_BIT]) |=> $stable(mask_o));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import prio_irq_pkg::*;
#(
   parameter int          NUM     = NUM_SRC,
   parameter int          VEC_W   = 16,
   parameter logic [15:0] GEN_VEC = 16'h0000
) (
   input  logic [NUM-1:0]   req_i,
   output logic             any_o,
   output src_e             win_o,
   output logic [VEC_W-1:0] vec_o
);

   if (NUM != NUM_SRC) begin : g_bad_num
      $error("irq_arbiter: source count must match the priority table");
   end
   if (VEC_W < 7 || VEC_W > 16) begin : g_bad_vec
      $error("irq_arbiter: vector width must hold the restart addresses");
   end

   assign any_o = |req_i;

   // scan lowest to highest so the highest-ranked request lands last
   always_comb begin
      win_o = SRC_NONE;
      vec_o = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            win_o = src_e'(3'(i));
            vec_o = VEC_W'(src_vector(i, GEN_VEC));
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int          VEC_W   = 16,
   parameter logic [15:0] GEN_VEC = 16'h0000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             trap_i,
   input  logic             r75_i,
   input  logic             r65_i,
   input  logic             r55_i,
   input  logic             gen_i,
   input  logic             ie_set_i,
   input  logic             ie_clr_i,
   input  logic             mask_wr_i,
   input  logic [7:0]       ctl_data_i,
   input  logic             ack_i,
   output logic             irq_pend_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             inta_no,
   output logic [7:0]       status_o
);

   logic              trap_rise, trap_armed, trap_clr;
   logic              r75_rise, r75_lat, r75_clr;
   logic              ie_q;
   logic [MASK_W-1:0] mask_q;
   logic [NUM_SRC-1:0] req_w;
   logic              take_w;
   src_e              win_w;

   assign take_w   = ack_i & irq_pend_o;
   assign trap_clr = take_w & (win_w == SRC_TRAP);
   assign r75_clr  = (take_w & (win_w == SRC_R75))
                   | (mask_wr_i & ctl_data_i[MW_CLR75_BIT]);

   irq_edge_latch #(.SET_WINS(1'b1)) u_trap_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(trap_i), .clr_i(trap_clr),
      .rise_o(trap_rise), .flag_o(trap_armed));

   irq_edge_latch #(.SET_WINS(1'b1)) u_r75_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(r75_i), .clr_i(r75_clr),
      .rise_o(r75_rise), .flag_o(r75_lat));

   irq_ctrl_regs u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ie_set_i), .dis_i(ie_clr_i),
      .ack_i(take_w), .mw_i(mask_wr_i), .mw_data_i(ctl_data_i),
      .ie_o(ie_q), .mask_o(mask_q));

   assign req_w[SRC_TRAP] = trap_i & trap_armed;
   assign req_w[SRC_R75]  = ie_q & ~mask_q[2] & r75_lat;
   assign req_w[SRC_R65]  = ie_q & ~mask_q[1] & r65_i;
   assign req_w[SRC_R55]  = ie_q & ~mask_q[0] & r55_i;
   assign req_w[SRC_GEN]  = ie_q & gen_i;

   irq_arbiter #(.NUM(NUM_SRC), .VEC_W(VEC_W), .GEN_VEC(GEN_VEC)) u_arb (
      .req_i(req_w), .any_o(irq_pend_o), .win_o(win_w), .vec_o(vec_o));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) inta_no <= 1'b1;
      else         inta_no <= ~(take_w & (win_w == SRC_GEN));
   end

   assign status_o = {1'b0, r75_lat, r65_i, r55_i, ie_q, mask_q};

   p_trap_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_i && trap_armed) |-> (irq_pend_o && vec_o == VEC_W'(16'h0024)));

   p_trap_rearm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_rise |=> trap_armed);

   p_masked_75_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_q[2] |-> (win_w != SRC_R75));

   p_ie_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ie_q |-> (!irq_pend_o || win_w == SRC_TRAP));

   p_inta_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_w && win_w == SRC_GEN) |=> !inta_no);

   p_inta_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !inta_no |=> inta_no);

   p_idle_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !irq_pend_o && !ie_set_i && !ie_clr_i && !mask_wr_i) |=> $stable(status_o[3:0]));

   p_r75_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      r75_rise |=> r75_lat);

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        trap_i = 0, r75_i = 0, r65_i = 0, r55_i = 0, gen_i = 0;
   logic        ie_set_i = 0, ie_clr_i = 0, mask_wr_i = 0, ack_i = 0;
   logic [7:0]  ctl_data_i = 8'h00;
   logic        irq_pend_o, inta_no;
   logic [15:0] vec_o;
   logic [7:0]  status_o;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk_i = ~clk_i;   // 250 MHz

   prio_irq_ctrl dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .trap_i(trap_i), .r75_i(r75_i),
      .r65_i(r65_i), .r55_i(r55_i), .gen_i(gen_i), .ie_set_i(ie_set_i),
      .ie_clr_i(ie_clr_i), .mask_wr_i(mask_wr_i), .ctl_data_i(ctl_data_i),
      .ack_i(ack_i), .irq_pend_o(irq_pend_o), .vec_o(vec_o),
      .inta_no(inta_no), .status_o(status_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk_i);
   endtask

   task automatic pulse_set();
      ie_set_i = 1; step(); ie_set_i = 0;
   endtask

   task automatic pulse_ack();
      ack_i = 1; step(); ack_i = 0;
   endtask

   task automatic mask_write(input logic [7:0] d);
      mask_wr_i = 1; ctl_data_i = d; step(); mask_wr_i = 0; ctl_data_i = 8'h00;
   endtask

   task automatic t_reset();
      chk("R7/R10 reset status", 32'(status_o), 32'h07);
      chk("R8 reset pending", 32'(irq_pend_o), 0);
      chk("R9 reset inta", 32'(inta_no), 1);
   endtask

   task automatic t_enable();
      pulse_set();
      chk("R8 set enable", 32'(status_o[3]), 1);
      ie_set_i = 1; ie_clr_i = 1; step(); ie_set_i = 0; ie_clr_i = 0;
      chk("R8 clear beats set", 32'(status_o[3]), 0);
      pulse_set();
   endtask

   task automatic t_mask();
      mask_write(8'h00);
      chk("R7 write without apply bit", 32'(status_o[2:0]), 7);
      mask_write(8'h08);
      chk("R7 apply bit writes masks", 32'(status_o[2:0]), 0);
   endtask

   task automatic t_idle_ack();
      pulse_ack();
      chk("R11 idle ack keeps enable", 32'(status_o), 32'h08);
   endtask

   task automatic t_levels();
      r55_i = 1; step();
      chk("R6 5.5 level pends", 32'(irq_pend_o), 1);
      chk("R1 5.5 vector", 32'(vec_o), 32'h002C);
      r65_i = 1; step();
      chk("R1 6.5 over 5.5", 32'(vec_o), 32'h0034);
      chk("R10 pending bits", 32'(status_o[6:4]), 3);
      mask_write(8'h0A);
      chk("R7 masked 6.5 loses", 32'(vec_o), 32'h002C);
      r65_i = 0; r55_i = 0; step();
      chk("R6 levels drop", 32'(irq_pend_o), 0);
      mask_write(8'h08);
   endtask

   task automatic t_edge75();
      r75_i = 1; step(); r75_i = 0; step();
      chk("R4 latched after pulse", 32'(vec_o), 32'h003C);
      chk("R10 7.5 status", 32'(status_o[6]), 1);
      pulse_ack();
      chk("R4 ack clears latch", 32'(status_o[6]), 0);
      chk("R8 ack clears enable", 32'(status_o[3]), 0);
      pulse_set();
      r75_i = 1; step();
      pulse_ack();
      pulse_set();
      step();
      chk("R4 held level no relatch", 32'(irq_pend_o), 0);
      r75_i = 0; step();
   endtask

   task automatic t_clr75();
      r75_i = 1; step(); r75_i = 0;
      chk("R5 latch set", 32'(status_o[6]), 1);
      mask_write(8'h18);
      chk("R5 mask write clears latch", 32'(status_o[6]), 0);
      chk("R5 masks written", 32'(status_o[2:0]), 0);
   endtask

   task automatic t_trap();
      ie_clr_i = 1; step(); ie_clr_i = 0;
      mask_write(8'h0F);
      trap_i = 1; step();
      chk("R2 trap ignores enable and masks", 32'(irq_pend_o), 1);
      chk("R1 trap vector", 32'(vec_o), 32'h0024);
      pulse_ack();
      step();
      chk("R3 held trap no retrigger", 32'(irq_pend_o), 0);
      trap_i = 0; step();
      trap_i = 1; step();
      chk("R3 new edge retriggers", 32'(irq_pend_o), 1);
      pulse_ack();
      trap_i = 0; step();
   endtask

   task automatic t_gen();
      pulse_set();
      mask_write(8'h08);
      gen_i = 1; step();
      chk("R1 general vector", 32'(vec_o), 32'h0000);
      chk("R9 inta idle", 32'(inta_no), 1);
      pulse_ack();
      chk("R9 inta low after ack", 32'(inta_no), 0);
      step();
      chk("R9 inta one cycle", 32'(inta_no), 1);
      gen_i = 0; step();
   endtask

   task automatic t_prio();
      pulse_set();
      trap_i = 1; r75_i = 1; r65_i = 1; r55_i = 1; gen_i = 1; step();
      r75_i = 0;
      chk("R1 trap first", 32'(vec_o), 32'h0024);
      pulse_ack();
      chk("R9 no inta for trap", 32'(inta_no), 1);
      pulse_set();
      chk("R1 7.5 second", 32'(vec_o), 32'h003C);
      pulse_ack(); pulse_set();
      chk("R1 6.5 third", 32'(vec_o), 32'h0034);
      r65_i = 0; step();
      chk("R1 5.5 fourth", 32'(vec_o), 32'h002C);
      r55_i = 0; step();
      chk("R1 general last", 32'(vec_o), 32'h0000);
      chk("R1 general pending", 32'(irq_pend_o), 1);
      trap_i = 0; gen_i = 0; step();
      chk("R1 all idle", 32'(irq_pend_o), 0);
   endtask

   task automatic t_collide();
      r55_i = 1; step();
      ack_i = 1; ie_set_i = 1; step(); ack_i = 0; ie_set_i = 0;
      chk("R8 ack beats set", 32'(status_o[3]), 0);
      r55_i = 0;
      r75_i = 1; mask_wr_i = 1; ctl_data_i = 8'h18; step();
      mask_wr_i = 0; ctl_data_i = 8'h00;
      chk("R5 edge beats clear", 32'(status_o[6]), 1);
      mask_write(8'h18);
      chk("R5 clear with level held", 32'(status_o[6]), 0);
      r75_i = 0; step();
   endtask

   initial begin
      repeat (20000) @(posedge clk_i);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      step(); step();
      rst_ni = 1;
      step();
      t_reset();
      t_enable();
      t_mask();
      t_idle_ack();
      t_levels();
      t_edge75();
      t_clr75();
      t_trap();
      t_gen();
      t_prio();
      t_collide();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule